// File: doc/BRIEF.md
# Logical Device Enable and I/O Conflict Probe

This block is the per-logical-device control slice of a plug-and-play expansion card. It holds three pieces of state for one logical device: an enable flag that puts the device on the host I/O bus, a conflict-probe control with an enable bit and a pattern-select bit, and a 16-bit I/O base address. The card's configuration state machine drives an index, a write-data byte and a write strobe into the block. It also raises a select line when this logical device is the one currently chosen. The card controller reads the registers back through the same index.

On the host side the block decodes I/O reads that fall in the window starting at the programmed base and spanning `WIN_LEN` bytes. An enabled device returns its own read data in that window. A device that is disabled but has the probe armed returns a fixed byte, 0x55 or 0xAA. Host software uses this to find out whether two cards claim the same ports. In every other case the block leaves the bus undriven. A one-cycle reset pulse from the card controller returns the device to its power-up state.

Top module: `ldev_ctl`

## Requirements
- R1: After `rst_n` is released, the enable flag, the probe control and the I/O base all read back as 0x00, and `bus_oe` is 0 with `bus_dout` = 0x00.
- R2: A selected write to index 0x30 loads the enable flag from write-data bit 0. A read of index 0x30 returns the flag in bit 0 and 0 in bits 7:1.
- R3: A selected write to index 0x31 loads the probe-enable bit from write-data bit 1 and the pattern-select bit from write-data bit 0. A read of index 0x31 returns them in those positions and 0 in bits 7:2.
- R4: Index 0x60 holds I/O base bits 15:8 and index 0x61 holds bits 7:0. Both are read/write. Any other index reads as 0x00.
- R5: Writes take effect only while `cfg_sel` is 1, so an unselected write leaves every register unchanged. While `cfg_sel` is 0, `cfg_rdata` is 0x00.
- R6: A write to index 0x30 with bit 0 set is ignored while probe-enable is 1, and the device stays disabled. A write with bit 0 clear always disables the device.
- R7: The window is every address A with base <= A < base + `WIN_LEN`, with no wrap past 0xFFFF. While the device is enabled, a host read (`host_rd` = 1) in the window sets `bus_oe` = 1 and `bus_dout` = `dev_rdata`. A read outside the window is not driven.
- R8: While the device is disabled and probe-enable is 1, a host read in the window returns 0x55 when pattern-select is 1 and 0xAA when it is 0, with `bus_oe` = 1.
- R9: When the device is disabled and the probe is off, or when `host_rd` is 0, `bus_oe` is 0 and `bus_dout` is 0x00.
- R10: A cycle with `ldev_reset` = 1 clears the enable flag, the probe control and the I/O base to 0. The reset wins over a write in the same cycle.
- R11: If the probe is armed after the device is enabled, window reads still return `dev_rdata`, not the probe pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldev_reset | input | 1 | Synchronous logical-device reset pulse from the card controller |
| cfg_sel | input | 1 | This logical device is the one currently selected |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_idx` |
| host_rd | input | 1 | Host I/O read cycle in progress |
| host_addr | input | ADDR_W | Host I/O address |
| dev_rdata | input | 8 | Read data from the device function |
| bus_oe | output | 1 | Drive enable for the host data bus |
| bus_dout | output | 8 | Byte placed on the host data bus |

## Verification
The bench probes the window at base - 1, base, base + `WIN_LEN` - 1 and base + `WIN_LEN`. An off-by-one in the decode would answer one address too many or one too few. It tries to enable the device while the probe is armed. A design without the interlock would enable the device and return device data where the probe pattern belongs. It arms the probe on a device that is already enabled, where a wrong priority would put 0x55 on top of live device data. It also writes with the select line low and writes in the same cycle as the device reset. A design that ignored either would show a changed base address on readback.

// File: rtl/ldev_ctl.sv
module ldev_ctl #(
  parameter int ADDR_W  = 16,
  parameter int WIN_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldev_reset,
  input  logic              cfg_sel,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        dev_rdata,
  output logic              bus_oe,
  output logic [7:0]        bus_dout
);
  localparam logic [7:0] IDX_EN    = 8'h30;
  localparam logic [7:0] IDX_PROBE = 8'h31;
  localparam logic [7:0] IDX_BHI   = 8'h60;
  localparam logic [7:0] IDX_BLO   = 8'h61;
  localparam logic [ADDR_W:0] LEN_X = (ADDR_W+1)'(WIN_LEN);

  logic              dev_en;
  logic              probe_en;
  logic              probe_pat;
  logic [ADDR_W-1:0] base;
  logic              wr_ok;
  logic [ADDR_W:0]   offs;
  logic              in_win;

  assign wr_ok = cfg_wr && cfg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_en    <= 1'b0;
      probe_en  <= 1'b0;
      probe_pat <= 1'b0;
      base      <= '0;
    end else if (ldev_reset) begin
      dev_en    <= 1'b0;
      probe_en  <= 1'b0;
      probe_pat <= 1'b0;
      base      <= '0;
    end else if (wr_ok) begin
      case (cfg_idx)
        IDX_EN:    if (!(cfg_wdata[0] && probe_en)) dev_en <= cfg_wdata[0];
        IDX_PROBE: begin
          probe_en  <= cfg_wdata[1];
          probe_pat <= cfg_wdata[0];
        end
        IDX_BHI:   base[ADDR_W-1:8] <= cfg_wdata[ADDR_W-9:0];
        IDX_BLO:   base[7:0]        <= cfg_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_sel) begin
      case (cfg_idx)
        IDX_EN:    cfg_rdata = {7'b0, dev_en};
        IDX_PROBE: cfg_rdata = {6'b0, probe_en, probe_pat};
        IDX_BHI:   cfg_rdata = 8'(base[ADDR_W-1:8]);
        IDX_BLO:   cfg_rdata = base[7:0];
        default:   cfg_rdata = 8'h00;
      endcase
    end
  end

  assign offs     = {1'b0, host_addr} - {1'b0, base};
  assign in_win   = !offs[ADDR_W] && (offs < LEN_X);
  assign bus_oe   = host_rd && in_win && (dev_en || probe_en);
  assign bus_dout = !bus_oe ? 8'h00 :
                    dev_en  ? dev_rdata :
                    probe_pat ? 8'h55 : 8'hAA;

  AST_ENABLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !ldev_reset && cfg_idx == IDX_EN && cfg_wdata[0] && probe_en && !dev_en) |=> !dev_en); // R6
  AST_DEVRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ldev_reset |=> (!dev_en && !probe_en && base == '0)); // R10
  AST_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sel && !ldev_reset) |=> ($stable(dev_en) && $stable(probe_en) && $stable(base))); // R5
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> host_rd); // R9
  AST_PROBE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !dev_en) |-> (bus_dout == 8'h55 || bus_dout == 8'hAA)); // R8
  AST_ENABLED_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && dev_en) |-> (bus_dout == dev_rdata)); // R11
endmodule

// File: tb/ldev_ctl_bench.sv
module ldev_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ldev_reset = 1'b0;
  logic        cfg_sel = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_idx = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        host_rd = 1'b0;
  logic [15:0] host_addr = 16'h0000;
  logic [7:0]  dev_rdata = 8'h5A;
  logic        bus_oe;
  logic [7:0]  bus_dout;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ldev_ctl #(.ADDR_W(16), .WIN_LEN(8)) u_ldev_ctl (
    .clk(clk), .rst_n(rst_n), .ldev_reset(ldev_reset), .cfg_sel(cfg_sel),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .host_rd(host_rd), .host_addr(host_addr),
    .dev_rdata(dev_rdata), .bus_oe(bus_oe), .bus_dout(bus_dout));

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d, input logic sel, input logic lrst);
    @(negedge clk);
    cfg_idx = idx; cfg_wdata = d; cfg_sel = sel; cfg_wr = 1'b1; ldev_reset = lrst;
    @(negedge clk);
    cfg_wr = 1'b0; ldev_reset = 1'b0; cfg_sel = 1'b0;
  endtask

  task automatic cfg_read(input string req, input logic [7:0] idx, input logic sel, input logic [7:0] exp);
    @(negedge clk);
    cfg_idx = idx; cfg_sel = sel;
    #1 check(req, {1'b0, cfg_rdata}, {1'b0, exp});
    cfg_sel = 1'b0;
  endtask

  task automatic host_read(input string req, input logic rd, input logic [15:0] a, input logic oe, input logic [7:0] d);
    @(negedge clk);
    host_rd = rd; host_addr = a;
    #1 check(req, {bus_oe, bus_dout}, {oe, d});
    host_rd = 1'b0;
  endtask

  task automatic t_reset();
    cfg_read("R1 enable", 8'h30, 1'b1, 8'h00);
    cfg_read("R1 probe", 8'h31, 1'b1, 8'h00);
    cfg_read("R1 base hi", 8'h60, 1'b1, 8'h00);
    cfg_read("R1 base lo", 8'h61, 1'b1, 8'h00);
    host_read("R1 R9 idle at base", 1'b1, 16'h0000, 1'b0, 8'h00);
  endtask

  task automatic t_regs();
    cfg_write(8'h30, 8'hFF, 1'b1, 1'b0);
    cfg_read("R2 enable set, upper zero", 8'h30, 1'b1, 8'h01);
    cfg_write(8'h30, 8'hFE, 1'b1, 1'b0);
    cfg_read("R2 enable clear", 8'h30, 1'b1, 8'h00);
    cfg_write(8'h31, 8'hFF, 1'b1, 1'b0);
    cfg_read("R3 probe bits", 8'h31, 1'b1, 8'h03);
    cfg_write(8'h31, 8'hFD, 1'b1, 1'b0);
    cfg_read("R3 pattern only", 8'h31, 1'b1, 8'h01);
    cfg_write(8'h31, 8'h00, 1'b1, 1'b0);
    cfg_write(8'h60, 8'h12, 1'b1, 1'b0);
    cfg_write(8'h61, 8'h34, 1'b1, 1'b0);
    cfg_read("R4 base hi", 8'h60, 1'b1, 8'h12);
    cfg_read("R4 base lo", 8'h61, 1'b1, 8'h34);
    cfg_read("R4 other index", 8'h45, 1'b1, 8'h00);
  endtask

  task automatic t_select();
    cfg_write(8'h60, 8'h99, 1'b0, 1'b0);
    cfg_read("R5 unselected write ignored", 8'h60, 1'b1, 8'h12);
    cfg_read("R5 unselected read zero", 8'h60, 1'b0, 8'h00);
  endtask

  task automatic t_probe();
    cfg_write(8'h31, 8'h03, 1'b1, 1'b0);
    host_read("R8 0x55 at base", 1'b1, 16'h1234, 1'b1, 8'h55);
    host_read("R7 below window", 1'b1, 16'h1233, 1'b0, 8'h00);
    host_read("R8 last in window", 1'b1, 16'h123B, 1'b1, 8'h55);
    host_read("R7 past window", 1'b1, 16'h123C, 1'b0, 8'h00);
    cfg_write(8'h31, 8'h02, 1'b1, 1'b0);
    host_read("R8 0xAA", 1'b1, 16'h1236, 1'b1, 8'hAA);
    host_read("R9 no read strobe", 1'b0, 16'h1236, 1'b0, 8'h00);
  endtask

  task automatic t_block();
    cfg_write(8'h30, 8'h01, 1'b1, 1'b0);
    cfg_read("R6 enable blocked", 8'h30, 1'b1, 8'h00);
    host_read("R6 still probing", 1'b1, 16'h1234, 1'b1, 8'hAA);
  endtask

  task automatic t_active();
    cfg_write(8'h31, 8'h00, 1'b1, 1'b0);
    cfg_write(8'h30, 8'h01, 1'b1, 1'b0);
    cfg_read("R2 enable after probe off", 8'h30, 1'b1, 8'h01);
    dev_rdata = 8'h5A;
    host_read("R7 device data", 1'b1, 16'h1235, 1'b1, 8'h5A);
    host_read("R7 outside window", 1'b1, 16'h0035, 1'b0, 8'h00);
    cfg_write(8'h31, 8'h03, 1'b1, 1'b0);
    dev_rdata = 8'hC3;
    host_read("R11 enabled wins over probe", 1'b1, 16'h1237, 1'b1, 8'hC3);
    cfg_write(8'h30, 8'h00, 1'b1, 1'b0);
    cfg_read("R6 disable allowed with probe on", 8'h30, 1'b1, 8'h00);
    host_read("R8 pattern after disable", 1'b1, 16'h1237, 1'b1, 8'h55);
    cfg_write(8'h31, 8'h00, 1'b1, 1'b0);
    host_read("R9 idle in window", 1'b1, 16'h1237, 1'b0, 8'h00);
  endtask

  task automatic t_ldreset();
    cfg_write(8'h30, 8'h01, 1'b1, 1'b0);
    cfg_write(8'h31, 8'h01, 1'b1, 1'b0);
    cfg_write(8'h60, 8'h77, 1'b1, 1'b1);
    cfg_read("R10 enable cleared", 8'h30, 1'b1, 8'h00);
    cfg_read("R10 probe cleared", 8'h31, 1'b1, 8'h00);
    cfg_read("R10 base hi cleared, write lost", 8'h60, 1'b1, 8'h00);
    cfg_read("R10 base lo cleared", 8'h61, 1'b1, 8'h00);
    host_read("R10 no drive at old base", 1'b1, 16'h1234, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_select();
    t_probe();
    t_block();
    t_active();
    t_ldreset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule